// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns three external pin inputs into interrupt requests for a CPU. Two of the pins are full-featured. Each takes one of four sense modes from a small control register: low level, any change, falling edge or rising edge. The third pin detects edges only, and a separate polarity input picks rising or falling for it. Every pin is first passed through a synchroniser. Edge events are held in a sticky per-pin flag until the CPU acknowledges them. A low-level request is never stored: it lasts exactly as long as the pin stays low.

Pins are sensed at the pad, whatever their output-enable state. Software can therefore raise an interrupt by driving its own pin. Each request passes through a per-pin mask and a global enable before it reaches `irq_o`.

A second, slow path serves wake-up. On each slow sampling tick the block samples the synchronised pins. It raises `wake_o` when an enabled level-mode pin reads low on two successive ticks, or when the last two slow samples of an enabled edge-mode pin form its selected edge.

Top module: `ext_irq_sense`

## Requirements
- R1: On a clock edge where `ctrl_we_i` is 1, `ctrl_wdata_i` is stored in the 8-bit control register. `ctrl_rdata_o` shows the stored value. The register resets to 0. Bits 7:4 are stored and read back but change neither requests nor pending state.
- R2: The sense field is bits 1:0 for pin 0 and bits 3:2 for pin 1. The encodings are 00 low level, 01 any change, 10 falling edge and 11 rising edge. An edge mode ignores the opposite edge.
- R3: Pin 2 is edge-only. `edge_rise_i`=1 selects the rising edge and 0 selects the falling edge. A held low level on pin 2 never produces a request by itself.
- R4: `irq_o[i]` can be 1 only if `gie_i` and `mask_i[i]` were both 1 at the preceding clock edge. Gating does not clear a pending flag. The same gate applies to each pin's contribution to `wake_o`.
- R5: In low-level mode, `irq_o[i]` is 1 while the pin is low and 0 once the pin is high again; nothing is latched. A pin change is visible at `irq_o` on the third rising clock edge after it is set up.
- R6: An edge or any-change event sets a sticky pending flag that keeps `irq_o[i]` high. A one-cycle `ack_i[i]` clears the flag, except when a new event arrives in the same cycle; the flag then stays set.
- R7: A pulse held for at least two clock periods always sets the pending flag in a matching edge mode.
- R8: No edge or level request is produced during the first three clock edges after reset. Pins that idle high across reset raise no request.
- R9: A change of a pin's sense selection clears that pin's pending flag. A write that leaves the pin's field unchanged keeps the flag.
- R10: On each clock edge where `slow_tick_i` is 1, the pins are sampled. `wake_o` is set when an enabled level-mode pin is low on this sample and on the previous one. One low sample is not enough, and the first sample after reset never wakes.
- R11: For an enabled edge-mode pin, `wake_o` is set when the previous and current slow samples form the selected edge. `wake_o` changes only at clock edges where `slow_tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 3 | Pad values of the three interrupt pins |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register contents |
| edge_rise_i | input | 1 | Pin 2 polarity: 1 rising, 0 falling |
| gie_i | input | 1 | Global interrupt enable |
| mask_i | input | 3 | Per-pin enable mask |
| ack_i | input | 3 | One-cycle per-pin acknowledge |
| slow_tick_i | input | 1 | Slow sampling strobe for the wake path |
| irq_o | output | 3 | Registered interrupt requests |
| wake_o | output | 1 | Registered wake request |

## Verification
Some properties are checked by assertions on every cycle:
- a masked pin never requests;
- a low level in level mode always requests on the next edge;
- a sense change always empties the pending flag;
- an acknowledge that meets an event leaves the flag set;
- nothing is pending before the synchroniser warms up;
- `wake_o` moves only on slow ticks and never on the first sample.

Other behaviour shows only in the bench's scenarios:
- the exact three-edge latency from pin to request;
- which edge each encoding selects;
- that control bits 7:4 leave behaviour unchanged;
- that a level request drops when the pin returns high;
- that one low slow sample is not enough while two are.

// File: rtl/eis_pkg.sv
package eis_pkg;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  // True when the pair (previous, current) forms the event the mode selects.
  function automatic logic edge_hit(sense_e mode, logic cur, logic prv);
    case (mode)
      SNS_ANY:  return cur ^ prv;
      SNS_FALL: return prv & ~cur;
      SNS_RISE: return ~prv & cur;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/eis_pin.sv
module eis_pin
  import eis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ready_i,
  input  logic       cur_i,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       ack_i,
  output logic       req_o,
  output logic       pend_o
);

  sense_e mode, mode_q;
  logic   prv, flag, flag_nxt, hit, lvl, chg;

  assign mode = sense_e'(mode_i);
  assign hit  = ready_i & edge_hit(mode, cur_i, prv);
  assign lvl  = ready_i & (mode == SNS_LOW) & ~cur_i;
  assign chg  = (mode != mode_q);

  // Mode change beats a new event, which beats an acknowledge.
  always_comb begin
    if (chg)      flag_nxt = 1'b0;
    else if (hit) flag_nxt = 1'b1;
    else if (ack_i) flag_nxt = 1'b0;
    else          flag_nxt = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prv    <= 1'b0;
      mode_q <= SNS_LOW;
      flag   <= 1'b0;
      req_o  <= 1'b0;
    end else begin
      prv    <= cur_i;
      mode_q <= mode;
      flag   <= flag_nxt;
      req_o  <= en_i & (lvl | flag_nxt);
    end
  end

  assign pend_o = flag;

  AST_LEVEL_REQ: assert property (@(posedge clk) disable iff (rst)
    (ready_i && en_i && mode == SNS_LOW && !cur_i) |=> req_o); // R5
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !req_o); // R4
  AST_MODE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (mode != mode_q) |=> !pend_o); // R9
  AST_ACK_KEEPS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (hit && ack_i && !chg) |=> pend_o); // R6
  AST_QUIET_WARMUP: assert property (@(posedge clk) disable iff (rst)
    !ready_i |=> !pend_o); // R8

endmodule

// File: rtl/eis_wake.sv
module eis_wake
  import eis_pkg::*;
#(
  parameter int N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready_i,
  input  logic              tick_i,
  input  logic [N-1:0]      cur_i,
  input  logic [N-1:0][1:0] mode_i,
  input  logic [N-1:0]      en_i,
  output logic              wake_o
);

  logic [N-1:0] smp;
  logic [N-1:0] cond;
  logic         primed;
  logic         take;

  assign take = tick_i & ready_i;

  for (genvar i = 0; i < N; i++) begin : g_cond
    always_comb begin
      if (sense_e'(mode_i[i]) == SNS_LOW)
        cond[i] = en_i[i] & ~cur_i[i] & ~smp[i];
      else
        cond[i] = en_i[i] & edge_hit(sense_e'(mode_i[i]), cur_i[i], smp[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp    <= '0;
      primed <= 1'b0;
      wake_o <= 1'b0;
    end else if (take) begin
      smp    <= cur_i;
      primed <= 1'b1;
      wake_o <= primed & (|cond);
    end
  end

  AST_WAKE_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(wake_o)); // R11
  AST_WAKE_NOT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (take && !primed) |=> !wake_o); // R10

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int N_FULL      = 2,
  parameter int CTRL_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_FULL:0]     pin_i,
  input  logic                ctrl_we_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  output logic [CTRL_W-1:0]   ctrl_rdata_o,
  input  logic                edge_rise_i,
  input  logic                gie_i,
  input  logic [N_FULL:0]     mask_i,
  input  logic [N_FULL:0]     ack_i,
  input  logic                slow_tick_i,
  output logic [N_FULL:0]     irq_o,
  output logic                wake_o
);

  localparam int N_PINS   = N_FULL + 1;
  localparam int FLD_W    = 2;
  localparam int WARM_MAX = SYNC_STAGES + 1;
  localparam int CNT_W    = $clog2(WARM_MAX + 1);

  logic [CTRL_W-1:0]         ctrl_q;
  logic [CNT_W-1:0]          warm;
  logic                      ready;
  logic [N_PINS-1:0]         pin_s;
  logic [N_PINS-1:0][1:0]    mode;
  logic [N_PINS-1:0]         en;
  logic [N_PINS-1:0]         pend;

  always_ff @(posedge clk) begin
    if (rst)            ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end
  assign ctrl_rdata_o = ctrl_q;

  // Hold off event detection until the synchroniser and history flop are valid.
  always_ff @(posedge clk) begin
    if (rst)        warm <= '0;
    else if (!ready) warm <= warm + 1'b1;
  end
  assign ready = (warm == CNT_W'(WARM_MAX));

  eis_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_mode
    if (i < N_FULL) begin : g_full
      assign mode[i] = ctrl_q[FLD_W*i +: FLD_W];
    end else begin : g_edge_only
      assign mode[i] = edge_rise_i ? SNS_RISE : SNS_FALL;
    end
  end

  assign en = {N_PINS{gie_i}} & mask_i;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    eis_pin u_pin (
      .clk     (clk),
      .rst     (rst),
      .ready_i (ready),
      .cur_i   (pin_s[i]),
      .mode_i  (mode[i]),
      .en_i    (en[i]),
      .ack_i   (ack_i[i]),
      .req_o   (irq_o[i]),
      .pend_o  (pend[i])
    );
  end

  eis_wake #(.N(N_PINS)) u_wake (
    .clk     (clk),
    .rst     (rst),
    .ready_i (ready),
    .tick_i  (slow_tick_i),
    .cur_i   (pin_s),
    .mode_i  (mode),
    .en_i    (en),
    .wake_o  (wake_o)
  );

  AST_CTRL_RESET: assert property (@(posedge clk)
    rst |=> (ctrl_rdata_o == '0)); // R1
  AST_EDGE_ONLY_NOT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (ready && !pend[N_FULL] && !ack_i[N_FULL]) |=> !(irq_o[N_FULL] && !pend[N_FULL])); // R3

endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] pin = 3'b111;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       erise = 1'b1;
  logic       gie = 1'b1;
  logic [2:0] mask = 3'b111;
  logic [2:0] ack = 3'b000;
  logic       tick = 1'b0;
  logic [2:0] irq;
  logic       wake;

  always #4 clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk          (clk),
    .rst          (rst),
    .pin_i        (pin),
    .ctrl_we_i    (we),
    .ctrl_wdata_i (wdata),
    .ctrl_rdata_o (rdata),
    .edge_rise_i  (erise),
    .gie_i        (gie),
    .mask_i       (mask),
    .ack_i        (ack),
    .slow_tick_i  (tick),
    .irq_o        (irq),
    .wake_o       (wake)
  );

  typedef struct {
    int         due;
    int         kind;   // 0 irq, 1 wake, 2 control readback
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  // Monitor: pops scoreboard items when due and compares against outputs.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = {5'b0, irq};
        1:       act = {7'b0, wake};
        default: act = rdata;
      endcase
      checks++;
      if (act !== it.val) begin
        fails++;
        $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", it.tag, act, it.val, cyc);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic expect_at(int lat, int kind, logic [7:0] v, string tag);
    item_t it;
    it.due = cyc + lat; it.kind = kind; it.val = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [7:0] v, string tag);
    we = 1'b1; wdata = v;
    expect_at(1, 2, v, tag);
    step(1);
    we = 1'b0;
  endtask

  task automatic do_ack(logic [2:0] a);
    ack = a; step(1); ack = 3'b000; step(1);
  endtask

  task automatic do_tick(logic exp, string tag);
    tick = 1'b1;
    expect_at(1, 1, {7'b0, exp}, tag);
    step(1);
    tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state, R8 no false edge with idle-high pins and rising pin 2
    expect_at(1, 2, 8'h00, "R1 reset ctrl");
    expect_at(1, 0, 8'h00, "R8 reset irq");
    expect_at(1, 1, 8'h00, "R10 reset wake");
    expect_at(6, 0, 8'h00, "R8 no false edge after reset");
    step(8);

    // R1 upper bits stored; level mode on pins 0/1
    wr(8'hF0, "R1 readback");
    step(2);
    pin[0] = 1'b0;
    expect_at(3, 0, 8'h01, "R1 R5 level low requests");
    step(5);
    pin[0] = 1'b1;
    expect_at(3, 0, 8'h00, "R5 level not latched");
    step(5);

    // R4 gating
    pin[0] = 1'b0;
    expect_at(3, 0, 8'h01, "R4 enabled level");
    step(5);
    mask = 3'b110;
    expect_at(1, 0, 8'h00, "R4 mask blocks");
    step(2);
    mask = 3'b111; gie = 1'b0;
    expect_at(1, 0, 8'h00, "R4 gie blocks");
    step(2);
    gie = 1'b1;
    expect_at(1, 0, 8'h01, "R4 re-enabled");
    step(2);
    pin[0] = 1'b1;
    step(5);

    // R2 any change on pin 1, R6 sticky / ack
    wr(8'h04, "R2 write any-change");
    step(2);
    pin[1] = 1'b0;
    expect_at(3, 0, 8'h02, "R2 any-change fall");
    step(3);
    expect_at(3, 0, 8'h02, "R6 sticky");
    step(3);
    ack = 3'b010;
    expect_at(1, 0, 8'h00, "R6 ack clears");
    step(1);
    ack = 3'b000;
    step(2);
    pin[1] = 1'b1;
    expect_at(3, 0, 8'h02, "R2 any-change rise");
    step(2);
    ack = 3'b010;
    expect_at(1, 0, 8'h02, "R6 ack with event");
    step(1);
    ack = 3'b000;
    expect_at(1, 0, 8'h02, "R6 flag kept after ack with event");
    step(1);
    do_ack(3'b010);
    step(2);

    // R7 two-cycle pulse, R2 falling mode on pin 0
    wr(8'h06, "R2 write falling");
    step(2);
    pin[0] = 1'b0;
    expect_at(3, 0, 8'h01, "R7 short pulse");
    step(2);
    pin[0] = 1'b1;
    step(5);
    expect_at(1, 0, 8'h01, "R7 pulse flag held");
    step(1);
    do_ack(3'b001);
    pin[0] = 1'b0;
    step(5);
    do_ack(3'b001);
    step(2);
    pin[0] = 1'b1;
    expect_at(4, 0, 8'h00, "R2 falling ignores rise");
    step(5);

    // R9 mode change clears, upper-bit write keeps
    pin[0] = 1'b0;
    expect_at(3, 0, 8'h01, "R2 falling detected");
    step(5);
    expect_at(3, 0, 8'h01, "R1 R9 upper-bit write keeps pending");
    wr(8'h16, "R1 readback upper");
    step(3);
    expect_at(3, 0, 8'h00, "R9 sense change clears");
    wr(8'h07, "R9 write rising");
    step(3);
    pin[0] = 1'b1;
    expect_at(3, 0, 8'h01, "R2 rising detected");
    step(5);
    do_ack(3'b001);
    step(2);

    // R3 pin 2 edge only
    pin[2] = 1'b0;
    expect_at(4, 0, 8'h00, "R3 rising mode ignores fall");
    step(5);
    pin[2] = 1'b1;
    expect_at(3, 0, 8'h04, "R3 rising edge");
    step(5);
    do_ack(3'b100);
    erise = 1'b0;
    step(3);
    pin[2] = 1'b0;
    expect_at(3, 0, 8'h04, "R3 falling edge");
    step(5);
    do_ack(3'b100);
    expect_at(3, 0, 8'h00, "R3 no level request");
    step(4);
    pin[2] = 1'b1;
    step(5);

    // R10 level wake on pin 0
    wr(8'h00, "R10 write level");
    mask = 3'b001;
    step(5);
    do_tick(1'b0, "R10 first sample no wake");
    step(3);
    pin[0] = 1'b0;
    step(4);
    do_tick(1'b0, "R10 one low sample not enough");
    step(3);
    do_tick(1'b1, "R10 two low samples wake");
    step(3);
    expect_at(1, 1, 8'h01, "R11 wake holds between ticks");
    step(2);
    pin[0] = 1'b1;
    step(4);
    do_tick(1'b0, "R10 high sample ends wake");
    step(3);

    // R11 edge wake on pin 1 (rising)
    wr(8'h0C, "R11 write rising");
    mask = 3'b010;
    step(3);
    pin[1] = 1'b0;
    step(4);
    do_tick(1'b0, "R11 fall is not rising");
    step(3);
    pin[1] = 1'b1;
    step(4);
    do_tick(1'b1, "R11 rising wakes");
    step(3);
    do_tick(1'b0, "R11 steady high no wake");
    step(3);
    gie = 1'b0;
    pin[1] = 1'b0;
    step(4);
    do_tick(1'b0, "R4 wake gated fall");
    step(3);
    pin[1] = 1'b1;
    step(4);
    do_tick(1'b0, "R4 wake gated rise");
    step(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule